// File: doc/BRIEF.md
# Masked Packed Unsigned-to-Double Converter

This block turns up to eight unsigned 32-bit integer lanes into IEEE-754 double-precision lanes in one clocked stage. The conversion is exact: any 32-bit unsigned value fits in the 53-bit significand of a double, so no rounding, no rounding-mode input and no floating-point exception flag exist. Each result lane is 64 bits wide and takes its source from the matching 32-bit slice of the source vector. With broadcast enabled, every lane takes the lowest source element instead.

A per-lane write mask decides which lanes receive a converted value. A mask-disable input overrides the mask and writes every lane. The lanes that are not written either keep the matching slice of a supplied prior destination value (merge mode) or become zero (zero mode). A length select limits the operation to 2, 4 or 8 lanes, and every result bit above the chosen length is cleared. A 4-bit reserved operand field must read all ones. Any other value raises an illegal-encoding flag, and the result is then of no interest to the consumer.

Inputs are sampled on a rising clock edge and both outputs are registered, so results appear one cycle after their operands.

Top module: `u2d_vec_cvt`

## Requirements
- R1: For an active, written lane with source value x, the 64-bit result is all zeros when x is 0. Otherwise the sign bit (bit 63) is 0, the exponent field (bits 62:52) is 1023 plus the index of the highest set bit of x, and the fraction field (bits 51:0) holds the bits of x below that leading one, left-aligned and padded with zeros. The value is exact.
- R2: `vl_sel` 2'b00 activates lanes 0..1, 2'b01 activates lanes 0..3, and 2'b10 or 2'b11 activates lanes 0..7. Every result bit of an inactive lane is 0.
- R3: Active lane j (bits 64j+63:64j) is written with the conversion of source bits 32j+31:32j when `lane_mask[j]` is 1 or `mask_off` is 1.
- R4: With `zero_mode` = 0 (merge), an active lane that is not written outputs bits 64j+63:64j of `prior_dst`.
- R5: With `zero_mode` = 1, an active lane that is not written outputs 0.
- R6: With `bcast` = 1, every written lane converts source bits 31:0 instead of its own element.
- R7: `bad_enc` is 1 exactly when `rsvd_field` differs from 4'b1111.
- R8: While `rst_n` is low at a rising edge, both outputs are cleared to 0 on that edge.
- R9: Outputs reflect the inputs sampled at the previous rising edge and hold their value between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| src_vec | input | 256 | Eight unsigned 32-bit source elements, element j at bits 32j+31:32j |
| prior_dst | input | 512 | Prior destination contents used by merge mode |
| lane_mask | input | 8 | Per-lane write enable, bit j for lane j |
| mask_off | input | 1 | 1 = write every active lane regardless of the mask |
| zero_mode | input | 1 | 0 = unwritten lanes merge, 1 = unwritten lanes are zeroed |
| vl_sel | input | 2 | Vector length: 00 = 2 lanes, 01 = 4 lanes, 1x = 8 lanes |
| bcast | input | 1 | 1 = all lanes convert source bits 31:0 |
| rsvd_field | input | 4 | Reserved operand field, legal only as 4'b1111 |
| result | output | 512 | Registered result, lane j at bits 64j+63:64j |
| bad_enc | output | 1 | Registered illegal-encoding flag |

## Verification
Both `result` and `bad_enc` are due on the first rising edge after their operands are applied. Nothing else is pipelined, so every scenario drives its operands on a falling edge, waits for one rising edge and compares on the next falling edge. The latency scenario also samples one nanosecond after the operands change, before any rising edge. There it expects the previous value, which shows that no output follows its inputs combinationally. The checker properties use the same single-cycle offset: each one compares the registered outputs against the one-cycle-old inputs, and only when the previous edge was outside reset.

// File: rtl/u2d_pkg.sv
// Package: shared constants and helpers for the unsigned-to-double converter.
// Assumes the IEEE-754 binary64 layout (1 sign, 11 exponent, 52 fraction bits).
package u2d_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    // Length select codes; the two upper codes both mean the widest setting.
    typedef enum logic [1:0] {
        LEN_SHORT = 2'b00,
        LEN_MID   = 2'b01,
        LEN_WIDE  = 2'b10,
        LEN_ALT   = 2'b11
    } len_sel_e;

    localparam logic [3:0] RSVD_OK = 4'b1111;

    // Number of active lanes for a length code, capped at the built lane count.
    function automatic int active_lanes(input len_sel_e sel, input int max_lanes);
        int n;
        case (sel)
            LEN_SHORT: n = 2;
            LEN_MID:   n = 4;
            default:   n = 8;
        endcase
        return (n > max_lanes) ? max_lanes : n;
    endfunction
endpackage

// File: rtl/u2d_lane_conv.sv
// Module: one exact unsigned-integer to binary64 converter lane.
// Assumes FRAC_W >= IN_W - 1 so every input is representable with no rounding.
module u2d_lane_conv
    import u2d_pkg::*;
#(
    parameter int IN_W = 32
) (
    input  logic [IN_W-1:0] val_in,
    output logic [FP_W-1:0] fp_out
);
    localparam int PAD_W = FRAC_W - IN_W;

    int                  msb_idx;
    logic [2*IN_W-1:0]   shifted;
    logic [EXP_W-1:0]    exp_f;
    logic [FRAC_W-1:0]   frac_f;

    // Find the position of the highest set bit (leading-one detect).
    always_comb begin
        msb_idx = 0;
        for (int b = 0; b < IN_W; b++) begin
            if (val_in[b]) msb_idx = b;
        end
    end

    // Normalise: move the leading one to bit IN_W, leaving the tail in the low half.
    always_comb begin
        shifted = {{IN_W{1'b0}}, val_in} << (IN_W - msb_idx);
        frac_f  = {shifted[IN_W-1:0], {PAD_W{1'b0}}};
        exp_f   = EXP_W'(BIAS + msb_idx);
    end

    // Pack the fields; zero input maps to positive zero.
    always_comb begin
        if (val_in == '0) fp_out = '0;
        else              fp_out = {1'b0, exp_f, frac_f};
    end
endmodule

// File: rtl/u2d_lane_wb.sv
// Module: per-lane writeback select (converted / prior / zero).
// Assumes lane_on already encodes the length limit for this lane.
module u2d_lane_wb
    import u2d_pkg::*;
(
    input  logic            lane_on,
    input  logic            wr_en,
    input  logic            zero_mode,
    input  logic [FP_W-1:0] conv_val,
    input  logic [FP_W-1:0] prior_val,
    output logic [FP_W-1:0] lane_out
);
    // Pick the lane value from length, write enable and masking mode.
    always_comb begin
        if (!lane_on)       lane_out = '0;
        else if (wr_en)     lane_out = conv_val;
        else if (zero_mode) lane_out = '0;
        else                lane_out = prior_val;
    end
endmodule

// File: rtl/u2d_vec_cvt.sv
// Module: top of the masked packed unsigned-to-double converter.
// Converts LANES unsigned elements to binary64 with write masking, broadcast,
// length limiting and a reserved-field check; outputs registered, one cycle latency.
// Assumes LANES <= 8 so the length codes map onto the built lanes.
module u2d_vec_cvt
    import u2d_pkg::*;
#(
    parameter int LANES = 8,
    parameter int IN_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES*IN_W-1:0] src_vec,
    input  logic [LANES*FP_W-1:0] prior_dst,
    input  logic [LANES-1:0]      lane_mask,
    input  logic                  mask_off,
    input  logic                  zero_mode,
    input  logic [1:0]            vl_sel,
    input  logic                  bcast,
    input  logic [3:0]            rsvd_field,
    output logic [LANES*FP_W-1:0] result,
    output logic                  bad_enc
);
    localparam int DST_W = LANES * FP_W;

    int               n_active;
    logic [DST_W-1:0] res_next;

    // Decode the length code into an active lane count.
    always_comb begin
        n_active = active_lanes(len_sel_e'(vl_sel), LANES);
    end

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            logic [IN_W-1:0] elem;
            logic [FP_W-1:0] conv;
            logic            on_j;

            // Choose own element or the broadcast low element.
            always_comb begin
                elem = bcast ? src_vec[IN_W-1:0] : src_vec[j*IN_W +: IN_W];
                on_j = (j < n_active);
            end

            u2d_lane_conv #(.IN_W(IN_W)) conv_i (
                .val_in (elem),
                .fp_out (conv)
            );

            u2d_lane_wb wb_i (
                .lane_on   (on_j),
                .wr_en     (mask_off | lane_mask[j]),
                .zero_mode (zero_mode),
                .conv_val  (conv),
                .prior_val (prior_dst[j*FP_W +: FP_W]),
                .lane_out  (res_next[j*FP_W +: FP_W])
            );
        end
    endgenerate

    // Register the result and the encoding flag; synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            bad_enc <= 1'b0;
        end else begin
            result  <= res_next;
            bad_enc <= (rsvd_field != RSVD_OK);
        end
    end
endmodule

// File: rtl/u2d_vec_cvt_chk.sv
// Module: property checker for u2d_vec_cvt, attached by bind.
// Observes ports only; every property compares outputs with one-cycle-old inputs.
module u2d_vec_cvt_chk (
    input logic         clk,
    input logic         rst_n,
    input logic [255:0] src_vec,
    input logic [511:0] prior_dst,
    input logic [7:0]   lane_mask,
    input logic         mask_off,
    input logic         zero_mode,
    input logic [1:0]   vl_sel,
    input logic [3:0]   rsvd_field,
    input logic [511:0] result,
    input logic         bad_enc
);
    p_bad_enc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bad_enc == ($past(rsvd_field) != 4'b1111)));

    p_short_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vl_sel) == 2'b00) |-> (result[511:128] == '0));

    p_mid_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vl_sel) == 2'b01) |-> (result[511:256] == '0));

    p_merge_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mask_off) && !$past(lane_mask[0]) && !$past(zero_mode))
        |-> (result[63:0] == $past(prior_dst[63:0])));

    p_zero_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mask_off) && !$past(lane_mask[0]) && $past(zero_mode))
        |-> (result[63:0] == '0));

    p_sign_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mask_off)) |-> (result[63] == 1'b0));

    p_zero_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mask_off) && $past(src_vec[31:0]) == 32'd0)
        |-> (result[63:0] == '0));

    p_reset_clear_r8: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (result == '0 && !bad_enc));
endmodule

bind u2d_vec_cvt u2d_vec_cvt_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_vec    (src_vec),
    .prior_dst  (prior_dst),
    .lane_mask  (lane_mask),
    .mask_off   (mask_off),
    .zero_mode  (zero_mode),
    .vl_sel     (vl_sel),
    .rsvd_field (rsvd_field),
    .result     (result),
    .bad_enc    (bad_enc)
);

// File: tb/u2d_vec_cvt_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios for u2d_vec_cvt, one task each, self-checking.
module u2d_vec_cvt_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [255:0] src_vec;
    logic [511:0] prior_dst;
    logic [7:0]   lane_mask;
    logic         mask_off;
    logic         zero_mode;
    logic [1:0]   vl_sel;
    logic         bcast;
    logic [3:0]   rsvd_field;
    logic [511:0] result;
    logic         bad_enc;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    u2d_vec_cvt dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_vec    (src_vec),
        .prior_dst  (prior_dst),
        .lane_mask  (lane_mask),
        .mask_off   (mask_off),
        .zero_mode  (zero_mode),
        .vl_sel     (vl_sel),
        .bcast      (bcast),
        .rsvd_field (rsvd_field),
        .result     (result),
        .bad_enc    (bad_enc)
    );

    // Reference conversion through the language's integer-to-real path (R1).
    function automatic logic [63:0] ref_conv(input logic [31:0] x);
        longint li;
        real    r;
        li = longint'({32'd0, x});
        r  = real'(li);
        return $realtobits(r);
    endfunction

    // Expected full result from the requirements R2..R6.
    function automatic logic [511:0] model(
        input logic [255:0] s, input logic [511:0] p, input logic [7:0] m,
        input logic mo, input logic zm, input logic [1:0] vl, input logic bc);
        logic [511:0] e;
        int n;
        n = (vl == 2'b00) ? 2 : (vl == 2'b01) ? 4 : 8;
        e = '0;
        for (int j = 0; j < 8; j++) begin
            if (j < n) begin
                if (mo || m[j])
                    e[j*64 +: 64] = ref_conv(bc ? s[31:0] : s[j*32 +: 32]);
                else if (!zm)
                    e[j*64 +: 64] = p[j*64 +: 64];
            end
        end
        return e;
    endfunction

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
        end
    endtask

    // Drive operands at a falling edge, pass one rising edge, compare at the next fall.
    task automatic run(input string tag, input logic [255:0] s, input logic [511:0] p,
                       input logic [7:0] m, input logic mo, input logic zm,
                       input logic [1:0] vl, input logic bc);
        @(negedge clk);
        src_vec = s; prior_dst = p; lane_mask = m; mask_off = mo;
        zero_mode = zm; vl_sel = vl; bcast = bc; rsvd_field = 4'hF;
        @(posedge clk);
        @(negedge clk);
        chk(tag, result, model(s, p, m, mo, zm, vl, bc));
    endtask

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // R8: outputs cleared while reset is held.
    task automatic t_reset();
        rst_n = 1'b0; src_vec = '1; prior_dst = '1; lane_mask = '1; mask_off = 1'b1;
        zero_mode = 1'b0; vl_sel = 2'b10; bcast = 1'b0; rsvd_field = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 result after reset", result, '0);
        chk("R8 bad_enc after reset", {511'd0, bad_enc}, '0);
        rst_n = 1'b1;
    endtask

    // R1: corner values converted in every lane of a full-length, unmasked operation.
    task automatic t_corners();
        logic [255:0] s;
        s = {32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'h0000_0000,
             32'h7FFF_FFFF, 32'h0000_0003, 32'h0001_0000, 32'h8000_0001};
        run("R1 corners", s, rnd512(), 8'h00, 1'b1, 1'b0, 2'b10, 1'b0);
        chk("R1 zero lane", {448'd0, result[64*4 +: 64]}, '0);
        chk("R1 one lane", {448'd0, result[64*5 +: 64]}, {448'd0, 64'h3FF0_0000_0000_0000});
        chk("R1 2^31 lane", {448'd0, result[64*6 +: 64]}, {448'd0, 64'h41E0_0000_0000_0000});
        chk("R1 all-ones lane", {448'd0, result[64*7 +: 64]}, {448'd0, 64'h41EF_FFFF_FFE0_0000});
    endtask

    // R1 / R3: random sources, all lanes written.
    task automatic t_random();
        for (int i = 0; i < 200; i++)
            run("R1 R3 random", rnd256(), rnd512(), 8'($urandom), 1'b1, 1'($urandom), 2'b10, 1'b0);
    endtask

    // R3 / R4 / R5: every mask pattern under both masking modes.
    task automatic t_masks();
        for (int m = 0; m < 256; m++) begin
            run("R3 R4 merge mask", rnd256(), rnd512(), 8'(m), 1'b0, 1'b0, 2'b10, 1'b0);
            run("R3 R5 zero mask", rnd256(), rnd512(), 8'(m), 1'b0, 1'b1, 2'b10, 1'b0);
        end
    endtask

    // R6: broadcast of the low element across lanes, with and without a mask.
    task automatic t_bcast();
        for (int i = 0; i < 20; i++) begin
            run("R6 bcast unmasked", rnd256(), rnd512(), 8'h00, 1'b1, 1'b0, 2'b10, 1'b1);
            run("R6 bcast masked", rnd256(), rnd512(), 8'($urandom), 1'b0, 1'($urandom), 2'b10, 1'b1);
        end
    endtask

    // R2: each length code, prior all ones so any leak above the length shows.
    task automatic t_len();
        for (int v = 0; v < 4; v++)
            for (int i = 0; i < 10; i++)
                run("R2 length", rnd256(), '1, 8'($urandom), 1'($urandom), 1'b0, 2'(v), 1'($urandom));
    endtask

    // R7: every reserved field value.
    task automatic t_rsvd();
        for (int r = 0; r < 16; r++) begin
            @(negedge clk);
            rsvd_field = 4'(r);
            @(posedge clk);
            @(negedge clk);
            chk("R7 bad_enc", {511'd0, bad_enc}, {511'd0, (r != 15)});
        end
        rsvd_field = 4'hF;
    endtask

    // R9: output holds until the next rising edge, then updates.
    task automatic t_latency();
        logic [511:0] old_v;
        logic [255:0] s;
        run("R9 setup", rnd256(), '0, 8'hFF, 1'b1, 1'b0, 2'b10, 1'b0);
        old_v = result;
        s = ~src_vec;
        @(negedge clk);
        src_vec = s;
        #1;
        chk("R9 held before edge", result, old_v);
        @(posedge clk);
        @(negedge clk);
        chk("R9 updated after edge", result, model(s, '0, 8'hFF, 1'b1, 1'b0, 2'b10, 1'b0));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 20);
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_corners();
        t_random();
        t_masks();
        t_bcast();
        t_len();
        t_rsvd();
        t_latency();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule